// File: doc/BRIEF.md
# Multi-Mode Window Watchdog

This block supervises a host processor with a single down-to-the-cycle counter that runs on the local oscillator clock. The host proves it is alive by presenting a service word on a one-cycle strobe. Each word carries redundant coding, and only words that pass the coding check are treated as a serve. The block then judges the timing of the serve against the active supervision behaviour. There are four behaviours: a long initial start-up period, a window check that rejects both early and late serves, a late-only check that can instead produce a cyclic wake-up pulse, and an off state for a controlled shutdown.

Any violation produces a one-cycle fault pulse with a 2-bit reason, and the counter starts again from zero. A requested behaviour and period are applied only at an accepted serve. A word with bad coding, or one that arrives too early, therefore never changes how the block supervises. The period comes from a compact table that holds seven doubling steps and one long entry.

Top module: `wdg_supervisor`

## Requirements
- R1: After a synchronous active-high reset, fault_o and wake_o are low, the behaviour is start-up, and the elapsed-cycle count is zero.
- R2: A service word is valid only when bits [7:4] equal the bitwise complement of bits [3:0]. A strobed invalid word gives a fault with reason 2 and restarts the count. The requested behaviour and period are not applied.
- R3: In start-up (mode code 0) no serve is ever early. If no serve arrives, a fault with reason 0 follows the STARTUP_TICKS-th clock edge after the last restart.
- R4: Mode codes are 0 start-up, 1 window, 2 late-only, 3 off. The period select picks 16<<sel ticks for sel 0..6 and 4096 ticks for sel 7. Mode and period are applied at an accepted serve.
- R5: In window mode (code 1), a valid serve at an edge where fewer than P/2 edges have elapsed since the last restart gives a fault with reason 1. It restarts the count and applies nothing.
- R6: In window mode, a valid serve with at least P/2 edges elapsed is accepted without a fault and restarts the count.
- R7: In window mode, and in late-only mode with wake disabled, a missing serve gives a fault with reason 0 right after the P-th edge since the last restart.
- R8: In late-only mode (code 2) a valid serve is accepted at any count.
- R9: In late-only mode with wake_en_i high, each expiry gives a one-cycle wake_o pulse instead of a fault and restarts the count. This repeats every P edges.
- R10: Off mode (code 3) is entered only through an accepted serve. While it is active there are no late faults, early faults or wake pulses. Invalid words still give a reason 2 fault, and a valid serve leaves off mode at once.
- R11: fault_o and wake_o are registered one-cycle pulses, one per event, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Requested behaviour, applied at an accepted serve |
| period_sel_i | input | 3 | Requested period select, applied at an accepted serve |
| wake_en_i | input | 1 | Late-only mode: expiry raises wake instead of a fault |
| serve_i | input | 1 | One-cycle strobe marking a service access |
| serve_word_i | input | 8 | Redundantly coded service word |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_reason_o | output | 2 | 0 late, 1 early, 2 bad code; updated with each fault |
| wake_o | output | 1 | One-cycle cyclic wake-up pulse |

## Verification
Almost all internal state shows up only through the time at which a pulse appears. A wrong elapsed count moves the late fault away from the exact P-th edge, or turns an on-time window serve into an early fault. The bench sees either error on the first period it measures. A behaviour or period applied when it should not be (after a bad code, an early serve, or an off request) stays hidden until the next serve or expiry. The bench therefore follows each such case at once with a serve or a full period measurement that can only pass under the unchanged setting.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WM_START = 2'd0,
    WM_WIN   = 2'd1,
    WM_TOUT  = 2'd2,
    WM_OFF   = 2'd3
  } wdg_mode_e;

  typedef enum logic [1:0] {
    RS_LATE  = 2'd0,
    RS_EARLY = 2'd1,
    RS_CODE  = 2'd2,
    RS_NONE  = 2'd3
  } wdg_rsn_e;

  typedef struct packed {
    logic late;
    logic early;
    logic bad;
    logic wake;
  } wdg_evt_t;

endpackage

// File: rtl/wdg_code_chk.sv
module wdg_code_chk #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              ok_o
);
  localparam int HALF = WORD_W / 2;

  logic [HALF-1:0] pair_ok;

  // each upper bit must be the inverse of its lower partner
  for (genvar b = 0; b < HALF; b++) begin : g_pair
    assign pair_ok[b] = word_i[b] ^ word_i[b+HALF];
  end

  assign ok_o = &pair_ok;
endmodule

// File: rtl/wdg_period_tbl.sv
module wdg_period_tbl #(
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 13,
  parameter int BASE_LOG2 = 4,
  parameter int TOP_LOG2  = 12
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] limit_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] lim_tbl [NSEL];

  // doubling steps, last entry jumps to the long period
  for (genvar i = 0; i < NSEL; i++) begin : g_ent
    localparam int LOG2_I = (i == NSEL - 1) ? TOP_LOG2 : BASE_LOG2 + i;
    assign lim_tbl[i] = CNT_W'((64'd1 << LOG2_I) - 64'd1);
  end

  assign limit_o = lim_tbl[sel_i];
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int CNT_W       = 13,
  parameter int STARTUP_LIM = 8191
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_req_i,
  input  logic [SEL_W-1:0] sel_req_i,
  input  logic             wake_en_i,
  input  logic             serve_i,
  input  logic             code_ok_i,
  input  logic [CNT_W-1:0] tbl_lim_i,
  output logic [SEL_W-1:0] sel_q_o,
  output wdg_evt_t         evt_o
);
  wdg_mode_e        mode_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit_cur;
  logic [CNT_W-1:0] half_cnt;
  logic             expire;
  logic             accept;
  logic             restart;

  assign sel_q_o   = sel_q;
  assign limit_cur = (mode_q == WM_START) ? CNT_W'(STARTUP_LIM) : tbl_lim_i;
  assign half_cnt  = (limit_cur >> 1) + CNT_W'(1);
  assign expire    = (cnt_q == limit_cur) && (mode_q != WM_OFF);

  always_comb begin
    evt_o  = '0;
    accept = 1'b0;
    if (serve_i) begin
      if (!code_ok_i)
        evt_o.bad = 1'b1;
      else if (mode_q == WM_WIN && cnt_q < half_cnt)
        evt_o.early = 1'b1;
      else
        accept = 1'b1;
    end else if (expire) begin
      if (mode_q == WM_TOUT && wake_en_i)
        evt_o.wake = 1'b1;
      else
        evt_o.late = 1'b1;
    end
  end

  assign restart = serve_i | expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= WM_START;
      sel_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (restart)
        cnt_q <= '0;
      else if (mode_q != WM_OFF)
        cnt_q <= cnt_q + CNT_W'(1);
      if (accept) begin
        mode_q <= wdg_mode_e'(mode_req_i);
        sel_q  <= sel_req_i;
      end
    end
  end

  // R7
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit_cur);

  // R10
  off_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == WM_OFF) |-> (!evt_o.late && !evt_o.wake && !evt_o.early));

  // R5
  early_only_window_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o.early |-> (mode_q == WM_WIN));

  // R2
  mode_needs_serve_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(serve_i && code_ok_i));

  // R11
  restart_after_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_o.late || evt_o.bad || evt_o.early || evt_o.wake) |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_evt_reg.sv
module wdg_evt_reg
  import wdg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wdg_evt_t evt_i,
  output logic     fault_o,
  output logic [1:0] reason_o,
  output logic     wake_o
);
  wdg_rsn_e rsn_next;
  logic     any_fault;

  assign any_fault = evt_i.late | evt_i.early | evt_i.bad;

  always_comb begin
    if (evt_i.bad)        rsn_next = RS_CODE;
    else if (evt_i.early) rsn_next = RS_EARLY;
    else if (evt_i.late)  rsn_next = RS_LATE;
    else                  rsn_next = RS_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o  <= 1'b0;
      wake_o   <= 1'b0;
      reason_o <= 2'd0;
    end else begin
      fault_o <= any_fault;
      wake_o  <= evt_i.wake;
      if (any_fault)
        reason_o <= rsn_next;
    end
  end

  // R11
  fault_wake_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && wake_o));

  // R2
  reason_legal_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (reason_o != 2'd3));
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
  parameter int WORD_W        = 8,
  parameter int SEL_W         = 3,
  parameter int BASE_LOG2     = 4,
  parameter int TOP_LOG2      = 12,
  parameter int STARTUP_TICKS = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  period_sel_i,
  input  logic              wake_en_i,
  input  logic              serve_i,
  input  logic [WORD_W-1:0] serve_word_i,
  output logic              fault_o,
  output logic [1:0]        fault_reason_o,
  output logic              wake_o
);
  localparam int MAX_TBL = 1 << TOP_LOG2;
  localparam int MAX_P   = (STARTUP_TICKS > MAX_TBL) ? STARTUP_TICKS : MAX_TBL;
  localparam int CNT_W   = $clog2(MAX_P);

  logic             code_ok;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] tbl_lim;
  wdg_pkg::wdg_evt_t evt;

  wdg_code_chk #(.WORD_W(WORD_W)) code_i (
    .word_i (serve_word_i),
    .ok_o   (code_ok)
  );

  wdg_period_tbl #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2), .TOP_LOG2(TOP_LOG2)
  ) tbl_i (
    .sel_i   (sel_q),
    .limit_o (tbl_lim)
  );

  wdg_timer #(
    .SEL_W(SEL_W), .CNT_W(CNT_W), .STARTUP_LIM(STARTUP_TICKS - 1)
  ) tmr_i (
    .clk        (clk),
    .rst        (rst),
    .mode_req_i (mode_i),
    .sel_req_i  (period_sel_i),
    .wake_en_i  (wake_en_i),
    .serve_i    (serve_i),
    .code_ok_i  (code_ok),
    .tbl_lim_i  (tbl_lim),
    .sel_q_o    (sel_q),
    .evt_o      (evt)
  );

  wdg_evt_reg evr_i (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt),
    .fault_o  (fault_o),
    .reason_o (fault_reason_o),
    .wake_o   (wake_o)
  );
endmodule

// File: tb/wdg_supervisor_tb_top.sv
module wdg_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic [2:0] period_sel_i = 3'd0;
  logic       wake_en_i = 1'b0;
  logic       serve_i = 1'b0;
  logic [7:0] serve_word_i = 8'h00;
  logic       fault_o;
  logic [1:0] fault_reason_o;
  logic       wake_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_supervisor dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .period_sel_i(period_sel_i),
    .wake_en_i(wake_en_i), .serve_i(serve_i), .serve_word_i(serve_word_i),
    .fault_o(fault_o), .fault_reason_o(fault_reason_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic serve(input logic [7:0] w, input logic [1:0] m, input logic [2:0] s,
                       output logic f, output logic [1:0] r);
    serve_i = 1'b1; serve_word_i = w; mode_i = m; period_sel_i = s;
    @(negedge clk);
    f = fault_o; r = fault_reason_o;
    serve_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    chk("R1 fault low after reset", fault_o, 0);
    chk("R1 wake low after reset", wake_o, 0);
  endtask

  task automatic t_startup();
    logic f; logic [1:0] r;
    tick(8191);
    chk("R3 no fault before start-up expiry", fault_o, 0);
    tick(1);
    chk("R3 late fault at start-up expiry", fault_o, 1);
    chk("R3 reason late", fault_reason_o, 0);
    tick(1);
    chk("R11 fault is one cycle", fault_o, 0);
    serve(8'h55, 2'd1, 3'd0, f, r);
    chk("R2 bad code faults", f, 1);
    chk("R2 bad code reason", r, 2);
    // immediate valid serve: an early fault would mean window was applied
    serve(8'hA5, 2'd1, 3'd0, f, r);
    chk("R2 bad code applied no mode / R3 no early in start-up", f, 0);
  endtask

  task automatic t_window();
    logic f; logic [1:0] r;
    tick(7);
    serve(8'h0F, 2'd1, 3'd1, f, r);
    chk("R5 early serve faults", f, 1);
    chk("R5 early reason", r, 1);
    tick(8);
    serve(8'h96, 2'd1, 3'd1, f, r);
    chk("R6 serve at half period accepted", f, 0);
    tick(31);
    chk("R4 no fault before 32 ticks", fault_o, 0);
    tick(1);
    chk("R7 late fault at 32 ticks", fault_o, 1);
    chk("R7 reason late", fault_reason_o, 0);
    tick(16);
    serve(8'hF0, 2'd1, 3'd7, f, r);
    chk("R6 serve at 16 of 32 accepted", f, 0);
    tick(4095);
    chk("R4 no fault before 4096 ticks", fault_o, 0);
    tick(1);
    chk("R4 late fault at 4096 ticks", fault_o, 1);
    tick(10);
    serve(8'hA5, 2'd1, 3'd0, f, r);
    chk("R5 early serve with new select faults", f, 1);
    tick(4095);
    chk("R5 early serve applied no period", fault_o, 0);
    tick(1);
    chk("R5 period still 4096", fault_o, 1);
  endtask

  task automatic t_timeout();
    logic f; logic [1:0] r;
    tick(2048);
    serve(8'h69, 2'd2, 3'd0, f, r);
    chk("R6 switch to late-only accepted", f, 0);
    tick(1);
    serve(8'h69, 2'd2, 3'd0, f, r);
    chk("R8 early serve accepted in late-only", f, 0);
    tick(15);
    chk("R7 no fault before 16 ticks", fault_o, 0);
    tick(1);
    chk("R7 late fault in late-only", fault_o, 1);
    wake_en_i = 1'b1;
    tick(15);
    chk("R9 no wake before expiry", wake_o, 0);
    tick(1);
    chk("R9 wake pulse at expiry", wake_o, 1);
    chk("R11 no fault with wake", fault_o, 0);
    tick(1);
    chk("R11 wake is one cycle", wake_o, 0);
    tick(14);
    chk("R9 no early second wake", wake_o, 0);
    tick(1);
    chk("R9 periodic wake", wake_o, 1);
  endtask

  task automatic t_off();
    logic f; logic [1:0] r;
    int seen = 0;
    serve(8'h55, 2'd3, 3'd0, f, r);
    chk("R10 bad code does not enter off", r, 2);
    tick(15);
    chk("R10 supervision still active", wake_o, 0);
    tick(1);
    chk("R10 wake still occurs", wake_o, 1);
    serve(8'hA5, 2'd3, 3'd0, f, r);
    chk("R10 off request accepted", f, 0);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (fault_o || wake_o) seen++;
    end
    chk("R10 silent in off", seen, 0);
    serve(8'h33, 2'd1, 3'd0, f, r);
    chk("R10 bad code faults in off", f, 1);
    chk("R10 bad code reason in off", r, 2);
    serve(8'hC3, 2'd1, 3'd0, f, r);
    chk("R10 leave off without early fault", f, 0);
    tick(15);
    chk("R10 window resumes", fault_o, 0);
    tick(1);
    chk("R10 late fault after leaving off", fault_o, 1);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_window();
    t_timeout();
    t_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1..: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule